// File: doc/BRIEF.md
# Half-Duplex Serial Converter Target Port

This block is the device side of the serial link of a two-channel, 12-bit sampling converter. A host lowers chip select, toggles a serial clock and sends a short request on the data input. The port skips any leading zeros and treats the first one it samples as a start marker. It then takes three configuration bits that choose the input pairing and the order of the result bits. After that it answers on the data output: first a single low null bit, then the conversion result.

The serial inputs are sampled in a faster system clock domain through synchronizers, and both serial clock edges are detected there. Input bits are taken on the rising serial clock edge and output bits are changed on the falling one. The data output has its own enable and stays released while the host is still sending, so the input and output can share one wire. A behavioural converter core receives a one-cycle start pulse together with the decoded mux setting, and returns the result on a parallel bus. The port latches that bus when the configuration completes.

Top module: `sadc_port`

## Requirements
- R1: While reset is applied and after it is released, with no frame in progress, `dout_oe`, `dout`, `conv_start` and `mux_sel` are all 0.
- R2: After `cs_n` falls, every 0 sampled on `din` at a rising `sclk` edge is skipped. The first 1 sampled is the start marker, so any number of leading zeros gives the same answer.
- R3: The three bits sampled after the start marker are, in arrival order, single-ended select S, odd/sign O and order select M. After they are captured, `mux_sel` becomes {S, O}. Bit 1 = 1 means the negative input is ground (single-ended). Bit 0 is the channel number (0 or 1) used as the positive input, in both single-ended and differential mode.
- R4: `conv_start` is high for exactly one system clock cycle per frame, in the cycle the third configuration bit is captured. The input bus `result` is latched in that same cycle.
- R5: `dout_oe` is 0 from the start of the frame through the capture of the configuration bits. It rises at the falling `sclk` edge that follows the last configuration bit, carrying a null bit of value 0. Whenever `dout_oe` is 0, `dout` is 0.
- R6: On the next 12 falling edges after the null bit, `dout` carries the latched result from bit 11 down to bit 0.
- R7: With M = 1, `dout` stays 0 on every falling edge after bit 0 until the frame ends.
- R8: With M = 0, bit 0 is sent once. The next 11 falling edges then carry bits 1 up to 11, and after that `dout` stays 0.
- R9: Once the configuration bits are captured, `din` has no effect on `dout` or `mux_sel` for the rest of the frame.
- R10: `cs_n` high at any point ends the frame: `dout_oe` drops, no `conv_start` is issued for a partly received configuration, and the next frame hunts for a new start marker.
- R11: `dout` changes only after a detected falling `sclk` edge, or when a frame is ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| result | input | 12 | Conversion result from the converter core |
| conv_start | output | 1 | One-cycle start request to the converter core |
| mux_sel | output | 2 | Decoded input pairing: {negative is ground, positive channel} |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for the data line driver |

## Verification
The frames are run with several leading-zero counts, from none up to five. This shows that start hunting does not depend on how long the host waits. All four single-ended/differential and odd/sign pairs are used, in both bit orders. The result values are asymmetric (a single low bit, a single high bit, all ones, mixed). With such values, a reversed order, a repeated or dropped bit 0, or a missing zero fill gives a different bit stream than a correct one. In some frames `din` is held high after the configuration to show that it is ignored. A frame aborted in the middle of its configuration must produce no start pulse and must leave the next frame unaffected.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int CFG_W = 3;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_CFG  = 2'd1,
    RX_DONE = 2'd2
  } rx_state_e;

  // first bit received sits at the top
  typedef struct packed {
    logic single;
    logic odd;
    logic msb_only;
  } cfg_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[g] <= RST_VAL;
      end else begin
        if (g == 0) stage[g] <= d;
        else        stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/sadc_rx.sv
module sadc_rx
  import sadc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_hi,
  input  logic sclk_rise,
  input  logic din_s,
  output logic conv_start,
  output cfg_t cfg,
  output logic cfg_done
);
  localparam int CNT_W = (CFG_W > 1) ? $clog2(CFG_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CFG_W - 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CFG_W-1:0] shreg_q, shreg_d;
  cfg_t             cfg_q;
  logic             start;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    start   = 1'b0;
    if (cs_hi) begin
      state_d = RX_HUNT;
      cnt_d   = '0;
    end else if (sclk_rise) begin
      unique case (state_q)
        RX_HUNT: begin
          if (din_s) begin
            state_d = RX_CFG;
            cnt_d   = '0;
          end
        end
        RX_CFG: begin
          shreg_d = {shreg_q[CFG_W-2:0], din_s};
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            state_d = RX_DONE;
            start   = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      shreg_q <= '0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      if (start) cfg_q <= cfg_t'(shreg_d);
    end
  end

  assign conv_start = start;
  assign cfg        = cfg_q;
  assign cfg_done   = (state_q == RX_DONE);
endmodule

// File: rtl/sadc_tx.sv
module sadc_tx #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_hi,
  input  logic              sclk_fall,
  input  logic              armed,
  input  logic              lsb_tail,
  input  logic [DATA_W-1:0] res,
  output logic              dout,
  output logic              dout_oe
);
  localparam int IDX_W = $clog2(2*DATA_W + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(2*DATA_W);

  logic             act_q, act_d;
  logic             oe_q, oe_d;
  logic             bit_q, bit_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  // slot 0 null, 1..DATA_W msb-first, then optional reversed tail
  function automatic logic pick(input logic [DATA_W-1:0] r, input logic tail, input int k);
    if (k == 0)                   return 1'b0;
    if (k <= DATA_W)              return r[DATA_W-k];
    if (tail && (k < 2*DATA_W))   return r[k-DATA_W];
    return 1'b0;
  endfunction

  always_comb begin
    act_d = act_q;
    oe_d  = oe_q;
    bit_d = bit_q;
    idx_d = idx_q;
    if (cs_hi) begin
      act_d = 1'b0;
      oe_d  = 1'b0;
      bit_d = 1'b0;
      idx_d = '0;
    end else if (sclk_fall && armed) begin
      if (!act_q) begin
        act_d = 1'b1;
        oe_d  = 1'b1;
        idx_d = '0;
        bit_d = 1'b0;
      end else begin
        if (idx_q != IDX_LAST) idx_d = idx_q + 1'b1;
        bit_d = pick(res, lsb_tail, int'(idx_d));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      oe_q  <= 1'b0;
      bit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      act_q <= act_d;
      oe_q  <= oe_d;
      bit_q <= bit_d;
      idx_q <= idx_d;
    end
  end

  assign dout    = bit_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/sadc_port.sv
module sadc_port
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] result,
  output logic              conv_start,
  output logic [1:0]        mux_sel,
  output logic              dout,
  output logic              dout_oe
);
  logic rst_meta, rst_sync_n;
  logic [2:0] pins_s;
  logic cs_hi, sclk_s, din_s, sclk_prev;
  logic sclk_rise, sclk_fall;
  logic cfg_done;
  cfg_t cfg;
  logic [DATA_W-1:0] res_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sadc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d    ({din, sclk, cs_n}),
    .q    (pins_s)
  );

  assign cs_hi  = pins_s[0];
  assign sclk_s = pins_s[1];
  assign din_s  = pins_s[2];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sclk_prev <= 1'b0;
    else             sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

  sadc_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_hi     (cs_hi),
    .sclk_rise (sclk_rise),
    .din_s     (din_s),
    .conv_start(conv_start),
    .cfg       (cfg),
    .cfg_done  (cfg_done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     res_q <= '0;
    else if (conv_start) res_q <= result;
  end

  sadc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cs_hi    (cs_hi),
    .sclk_fall(sclk_fall),
    .armed    (cfg_done),
    .lsb_tail (~cfg.msb_only),
    .res      (res_q),
    .dout     (dout),
    .dout_oe  (dout_oe)
  );

  assign mux_sel = {cfg.single, cfg.odd};
endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       sclk_fall,
  input logic       conv_start,
  input logic [1:0] mux_sel,
  input logic       dout,
  input logic       dout_oe
);
  assert_single_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_mux_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_sel != $past(mux_sel)) |-> $past(conv_start));

  assert_null_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> !dout);

  assert_quiet_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (!dout_oe && !conv_start));

  assert_fall_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(sclk_fall || cs_hi));
endmodule

bind sadc_port sadc_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_hi     (cs_hi),
  .sclk_fall (sclk_fall),
  .conv_start(conv_start),
  .mux_sel   (mux_sel),
  .dout      (dout),
  .dout_oe   (dout_oe)
);

// File: tb/tb_sadc_port.sv
module tb_sadc_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8 * CLK_PERIOD;
  localparam int NREAD      = 28;
  localparam int NVEC       = 6;
  // {lead[3:0], S, O, M, din after config, result[11:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd0, 3'b111, 1'b0, 12'hA5C},
    {4'd3, 3'b110, 1'b1, 12'h801},
    {4'd1, 3'b000, 1'b0, 12'h3C6},
    {4'd5, 3'b011, 1'b1, 12'hFFF},
    {4'd2, 3'b101, 1'b1, 12'h001},
    {4'd4, 3'b010, 1'b0, 12'hFFE}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din;
  logic [11:0] result;
  logic conv_start, dout, dout_oe;
  logic [1:0] mux_sel;
  int checks = 0, fails = 0, starts = 0;

  sadc_port dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .result(result), .conv_start(conv_start), .mux_sel(mux_sel),
    .dout(dout), .dout_oe(dout_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (conv_start) starts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [11:0] r, input logic m, input int j);
    if (j == 0)              return 1'b0;
    if (j <= 12)             return r[12-j];
    if (!m && j < 24)        return r[j-12];
    return 1'b0;
  endfunction

  // one sclk period: drive din, sample just before rise
  task automatic sbit(input logic d, output logic o, output logic oe);
    din = d;
    #(HALF);
    o  = dout;
    oe = dout_oe;
    sclk = 1'b1;
    #(HALF);
    sclk = 1'b0;
  endtask

  task automatic run_frame(input int lead, input logic [2:0] cfg, input logic tail,
                           input logic [11:0] res, input string tag);
    logic o, oe;
    logic [NREAD-1:0] got, exp;
    logic [2:0] cfg_oe;
    logic all_oe;
    int s0;
    s0 = starts;
    result = res;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < lead; i++) sbit(1'b0, o, oe);
    sbit(1'b1, o, oe);
    for (int i = 0; i < 3; i++) begin
      sbit(cfg[2-i], o, oe);
      cfg_oe[i] = oe;
    end
    all_oe = 1'b1;
    for (int j = 0; j < NREAD; j++) begin
      sbit(tail, o, oe);
      got[j] = o;
      exp[j] = exp_bit(res, cfg[0], j);
      all_oe = all_oe & oe;
    end
    // R2 R6 R7 R8 R9: whole answer stream
    chk(got == exp, {"R2 R6 R7 R8 R9 stream ", tag}, int'(got), int'(exp));
    chk(cfg_oe == 3'b000 && all_oe, {"R5 enable window ", tag}, int'({cfg_oe, all_oe}), 1);
    chk(mux_sel == cfg[2:1], {"R3 mux_sel ", tag}, int'(mux_sel), int'(cfg[2:1]));
    chk(starts == s0 + 1, {"R4 one start pulse ", tag}, starts - s0, 1);
    cs_n = 1'b1;
    #(HALF);
    chk(!dout_oe && !dout, {"R10 release on cs ", tag}, int'({dout_oe, dout}), 0);
    #(HALF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic o, oe;
    int s0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; result = '0;
    #(4*CLK_PERIOD);
    chk(!dout_oe && !dout && !conv_start && mux_sel == 2'b00, "R1 in reset",
        int'({dout_oe, dout, conv_start, mux_sel}), 0);
    rst_n = 1'b1;
    #(10*CLK_PERIOD);
    chk(!dout_oe && !dout && !conv_start && mux_sel == 2'b00, "R1 after reset",
        int'({dout_oe, dout, conv_start, mux_sel}), 0);

    for (int v = 0; v < NVEC; v++)
      run_frame(int'(VEC[v][19:16]), VEC[v][15:13], VEC[v][12], VEC[v][11:0], $sformatf("vec%0d", v));

    // R10: abort inside configuration, no start pulse, output stays off
    s0 = starts;
    cs_n = 1'b0;
    #(HALF);
    sbit(1'b0, o, oe);
    sbit(1'b1, o, oe);
    sbit(1'b0, o, oe);
    sbit(1'b1, o, oe);
    cs_n = 1'b1;
    #(2*HALF);
    chk(starts == s0, "R10 no start after abort", starts - s0, 0);
    chk(!dout_oe, "R10 output off after abort", int'(dout_oe), 0);
    chk(mux_sel == VEC[NVEC-1][15:14], "R10 mux_sel kept after abort",
        int'(mux_sel), int'(VEC[NVEC-1][15:14]));
    // next frame starts clean with a fresh start hunt
    run_frame(2, 3'b100, 1'b1, 12'h5A3, "after abort");
    run_frame(0, 3'b001, 1'b0, 12'h000, "zero result");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule